// File: doc/BRIEF.md
# One-Pulse-Per-Second Pin Generator

This block produces a square wave with a period of exactly one second. The wave is locked to the nanoseconds field of a local time-of-day counter. Because the wave is worked out from the counter value on every cycle, there is no start-time register and no period register. When the seconds field increments, the nanoseconds field wraps to zero, and the wave's leading edge lands on that wrap. When the counter is stepped or slewed, the wave follows on the next cycle without any resynchronisation.

Software controls the block through a simple write port. A control word holds an enable flag and an inversion flag. Setting the inversion flag moves the visible rising edge by half a second, which is the only phase control. A bank of per-pin function words, one for each general-purpose pin, chooses which pin carries the wave. A pin whose function word holds the wave-output code drives the wave. Every other pin stays low. If several pins hold that code, only the lowest-numbered one is driven.

The counter itself, its rate adjustment and the management bus that carries register accesses all sit outside this block.

Top module: `pps_pin_gen`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, every pin of `pin_out` is 0. The control word and all pin function words read as zero, so the pins remain 0 until software writes them.
- R2: When enabled with the inversion flag at 0, the selected pin is 1 while `tod_nsec` < 500,000,000 and 0 otherwise. The pin is registered: it reflects the `tod_nsec` value and register state present at the previous clock edge.
- R3: When the inversion flag is 1, the selected pin's level is inverted. The pin is then 1 while `tod_nsec` >= 500,000,000.
- R4: A write to address `CTRL_ADDR` (default 0x02) loads the enable flag from bit 3 and the inversion flag from bit 2. If bit 3 is 0, both flags are cleared, whatever the value of bit 2.
- R5: While the enable flag is 0, every pin is 0 for any `tod_nsec` value.
- R6: A write to address `PIN_BASE + i` (default base 0x40, i from 0 to `NUM_PINS`-1) stores a 16-bit function word for pin i. Only the exact word 0x8052 selects the wave output: bit 15 for function enable, bit 6 for the timing group, and signal code 0x12 in bits 5:0. Any other word, including 0, holds the pin at 0.
- R7: When several pins hold 0x8052, only the lowest-numbered one carries the wave. All the others are 0, so at most one pin is ever 1.
- R8: The wave has no start time and no internal timer. Stepping `tod_nsec` across the 500,000,000 boundary, in either direction, changes the selected pin on the next cycle.
- R9: Writes to addresses that map to neither the control word nor a pin function word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_nsec | input | NSEC_W (30) | Nanoseconds field of the local time-of-day counter |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (8) | Register write address |
| cfg_wdata | input | 16 | Register write data |
| pin_out | output | NUM_PINS (12) | General-purpose pin outputs |

## Verification
The time counter is advanced in large steps, so many full seconds pass in a short run. The wave is checked with the inversion flag both clear and set, which separates the two half-second phases. Pins are tried with the exact selection word, a word missing the group bit, and zero, which separates an exact-match decode from a partial one. Several pins are configured at once to expose the lowest-index priority. Direct jumps of the counter across the half-second and whole-second boundaries show that the output has no timer of its own. Two further patterns show that disabling really clears the inversion flag and that stray addresses leave the state untouched: a disable that carries a set inversion bit, and writes to unmapped addresses.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] PIN_WORD_PPS = 16'h8052;
  localparam int CTRL_EN_BIT  = 3;
  localparam int CTRL_POL_BIT = 2;
endpackage

// File: rtl/pps_cfg_regs.sv
module pps_cfg_regs
  import pps_pkg::*;
#(
  parameter int NUM_PINS  = 12,
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 8'h02,
  parameter int PIN_BASE  = 8'h40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic                en,
  output logic                pol,
  output logic [NUM_PINS-1:0] pin_is_pps
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic ctrl_hit;
  assign ctrl_hit = cfg_we && (cfg_addr == CTRL_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      pol <= 1'b0;
    end else if (ctrl_hit) begin
      en  <= cfg_wdata[CTRL_EN_BIT];
      pol <= cfg_wdata[CTRL_EN_BIT] & cfg_wdata[CTRL_POL_BIT];
    end
  end

  // R4: a disabling write leaves both flags cleared
  a_r4_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && !cfg_wdata[CTRL_EN_BIT]) |=> (!en && !pol));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      localparam logic [ADDR_W-1:0] PIN_A = ADDR_W'(PIN_BASE + gi);
      logic [CFG_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)
          word_q <= '0;
        else if (cfg_we && (cfg_addr == PIN_A))
          word_q <= cfg_wdata;
      end
      assign pin_is_pps[gi] = (word_q == PIN_WORD_PPS);
    end
  endgenerate
endmodule

// File: rtl/pps_wave.sv
module pps_wave #(
  parameter int NSEC_W  = 30,
  parameter int HALF_NS = 500_000_000
) (
  input  logic              en,
  input  logic              pol,
  input  logic [NSEC_W-1:0] tod_nsec,
  output logic              level
);
  localparam logic [NSEC_W-1:0] HALF = NSEC_W'(HALF_NS);

  logic first_half;
  assign first_half = (tod_nsec < HALF);
  assign level      = en & (first_half ^ pol);
endmodule

// File: rtl/pps_pin_mux.sv
module pps_pin_mux #(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                level,
  input  logic [NUM_PINS-1:0] pin_is_pps,
  output logic [NUM_PINS-1:0] pin_out
);
  logic [NUM_PINS-1:0] grant;

  // isolate lowest set bit: lowest pin index wins
  assign grant = pin_is_pps & (~pin_is_pps + NUM_PINS'(1));

  always_ff @(posedge clk) begin
    if (rst)
      pin_out <= '0;
    else
      pin_out <= level ? grant : '0;
  end

  // R7: at most one pin carries the wave
  a_r7_single_pin: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pin_out));
endmodule

// File: rtl/pps_pin_gen.sv
module pps_pin_gen
  import pps_pkg::*;
#(
  parameter int NUM_PINS  = 12,
  parameter int ADDR_W    = 8,
  parameter int NSEC_W    = 30,
  parameter int HALF_NS   = 500_000_000,
  parameter int CTRL_ADDR = 8'h02,
  parameter int PIN_BASE  = 8'h40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSEC_W-1:0]   tod_nsec,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [NUM_PINS-1:0] pin_out
);
  localparam logic [NSEC_W-1:0] HALF = NSEC_W'(HALF_NS);

  logic                en, pol, level;
  logic [NUM_PINS-1:0] pin_is_pps;

  pps_cfg_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .PIN_BASE(PIN_BASE)
  ) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en(en), .pol(pol), .pin_is_pps(pin_is_pps)
  );

  pps_wave #(.NSEC_W(NSEC_W), .HALF_NS(HALF_NS)) i_wave (
    .en(en), .pol(pol), .tod_nsec(tod_nsec), .level(level)
  );

  pps_pin_mux #(.NUM_PINS(NUM_PINS)) i_mux (
    .clk(clk), .rst(rst), .level(level),
    .pin_is_pps(pin_is_pps), .pin_out(pin_out)
  );

  // R5: disabled means all pins low next cycle
  a_r5_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pin_out == '0));
  // R2: non-inverted wave is low in the second half
  a_r2_second_half_low: assert property (@(posedge clk) disable iff (rst)
    (en && !pol && tod_nsec >= HALF) |=> (pin_out == '0));
  // R3: inverted wave is low in the first half
  a_r3_first_half_low: assert property (@(posedge clk) disable iff (rst)
    (en && pol && tod_nsec < HALF) |=> (pin_out == '0));
  // R1: after a reset edge all pins are low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (pin_out == '0));
endmodule

// File: tb/test_pps_pin_gen.sv
module test_pps_pin_gen;
  localparam int NP   = 12;
  localparam int NS   = 1_000_000_000;
  localparam int HALF = 500_000_000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [29:0]   tod_nsec = '0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic [NP-1:0] pin_out;

  pps_pin_gen i_pps_pin_gen (
    .clk(clk), .rst(rst), .tod_nsec(tod_nsec), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pin_out(pin_out)
  );

  always #5 clk = ~clk;

  int     n_checks = 0;
  int     n_fail   = 0;
  string  cur_req  = "R1";
  int     step     = 50_000_000;
  bit     started  = 0;
  bit     done     = 0;

  // behavioural reference model
  bit          m_en, m_pol;
  int          m_cfg[NP];
  logic [NP-1:0] exp_out;

  always @(posedge clk) begin
    logic [NP-1:0] nxt;
    bit lvl;
    nxt = '0;
    if (rst) begin
      m_en = 0; m_pol = 0;
      foreach (m_cfg[k]) m_cfg[k] = 0;
    end else begin
      lvl = m_en && ((int'(tod_nsec) < HALF) != m_pol);
      if (lvl) begin
        for (int k = 0; k < NP; k++) begin
          if (m_cfg[k] == 'h8052) begin
            nxt[k] = 1'b1;
            break;
          end
        end
      end
      if (cfg_we) begin
        if (cfg_addr == 8'h02) begin
          m_en  = cfg_wdata[3];
          m_pol = cfg_wdata[3] && cfg_wdata[2];
        end else if (cfg_addr >= 8'h40 && cfg_addr < 8'h40 + NP) begin
          m_cfg[cfg_addr - 8'h40] = int'(cfg_wdata);
        end
      end
    end
    exp_out = nxt;
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_checks++;
      if (pin_out !== exp_out) begin
        n_fail++;
        $display("FAIL %s: pin_out=%h expected=%h nsec=%0d", cur_req,
                 pin_out, exp_out, tod_nsec);
      end
    end
  end

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk); #2;
      tod_nsec = 30'((int'(tod_nsec) + step) % NS);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic set_ns(int v);
    @(posedge clk); #2;
    tod_nsec = 30'(v);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    run(5);
    // R2: normal polarity wave on pin 5
    cur_req = "R2";
    wr(8'h45, 16'h8052);
    wr(8'h02, 16'h0008);
    run(60);
    // R3: inverted
    cur_req = "R3";
    wr(8'h02, 16'h000C);
    run(40);
    // R4: disable with polarity bit set clears polarity
    cur_req = "R4";
    wr(8'h02, 16'h0004);
    run(20);
    wr(8'h02, 16'h0008);
    run(25);
    // R5: disabled output stays low
    cur_req = "R5";
    wr(8'h02, 16'h0000);
    run(30);
    // R6: exact word decode
    cur_req = "R6";
    wr(8'h02, 16'h0008);
    wr(8'h45, 16'h8012);
    run(25);
    wr(8'h45, 16'h0000);
    wr(8'h4B, 16'h8052);
    run(25);
    // R7: lowest index wins
    cur_req = "R7";
    wr(8'h43, 16'h8052);
    run(25);
    wr(8'h43, 16'h0000);
    run(25);
    // R8: counter steps followed at once
    cur_req = "R8";
    step = 0;
    set_ns(999_999_990); run(2);
    set_ns(0);           run(2);
    set_ns(499_999_999); run(2);
    set_ns(500_000_000); run(2);
    set_ns(250_000_000); run(2);
    set_ns(700_000_000); run(2);
    wr(8'h02, 16'h000C);
    set_ns(100); run(2);
    set_ns(900_000_000); run(2);
    step = 70_000_000;
    // R9: unmapped writes ignored
    cur_req = "R9";
    wr(8'h01, 16'h0000);
    wr(8'h03, 16'h0000);
    wr(8'h4C, 16'h8052);
    wr(8'h3F, 16'h8052);
    run(30);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule